// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Interface Model

This block is a synthesizable digital stand-in for the serial side of a twelve-bit sampling converter. It lets a host controller design be exercised against realistic bit-level timing without any analog parts. The host drives a serial clock, an active-low select, a data line and an active-low shutdown line. The block oversamples all four with its own system clock. It decodes an eight-bit control word and marks the track and hold windows. It then walks a twelve-step binary search against a digital sample that the surrounding test harness presents on a port. The result leaves on the data output one bit per serial clock, most significant bit first, and a strobe pulse one serial period ahead of the first result bit gives early warning.

The harness supplies `sample_diff`, the positive input minus the negative input in LSB units, as a 14-bit two's complement value. For single-ended use the negative input is the common pin, so the harness passes the channel level itself. The two serial outputs come with enable signals that stand for their high-impedance state. The block also keeps the power state that the last completed control word requested, wakes itself when the interface is used, and yields to the hardware shutdown pin. All serial timing below is counted in edges of `sclk`, and the result appears a fixed few system clocks after each edge.

Top module: `sadc_model`

## Requirements
- R1: While cs_n is low and shdn_n is high, din is taken on sclk rising edges. Zeros ahead of the first 1 (the start bit) are discarded and do not wake the block. The control word travels MSB first: bit 7 start, bits 6:4 channel, bit 3 unipolar flag (1 = unipolar, 0 = bipolar), bit 2 single-ended flag, bits 1:0 power bits. While cs_n is high, sclk and din have no effect.
- R2: track rises on the sclk falling edge that follows the fifth control bit, and chan_sel then holds the channel field.
- R3: track falls on the sclk falling edge after the eighth control bit. sample_diff is captured at that point, and single_ended takes bit 2 of the word.
- R4: sstrb is high for exactly the sclk period that begins at the first rising edge after the hold point (rising edge 9 counted from the start bit), and low at all other times.
- R5: While cs_n is high, dout_oe and sstrb_oe are low and dout and sstrb are low. Raising cs_n abandons any sequence in flight, leaves the power mode unchanged, and the next control word converts normally.
- R6: From rising edge 10, dout carries the twelve result bits MSB first, one per rising edge, with the LSB at edge 21. After that it stays 0 until a later result bit.
- R7: In unipolar mode the result is straight binary of sample_diff clamped to 0..4095.
- R8: In bipolar mode the result is the twelve-bit two's complement of sample_diff clamped to -2048..2047.
- R9: pwr_state is 4 after reset. After the LSB of a conversion it follows the word's power bits: 00 gives 1 (full power-down), 01 gives 2 (fast power-down), 10 gives 3 (reduced power), 11 gives 4 (normal).
- R10: A start bit received in any software mode sets pwr_state to 4 until the conversion ends or is abandoned.
- R11: While shdn_n is low, pwr_state is 0 and serial input is ignored: no tracking, no strobe, no result, no mode change. After release the state held before the shutdown returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data |
| shdn_n | input | 1 | Active-low hardware shutdown |
| sample_diff | input | 14 | Positive minus negative input in LSB, two's complement |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout (low means high impedance) |
| sstrb | output | 1 | Early-warning strobe ahead of the MSB |
| sstrb_oe | output | 1 | Drive enable for sstrb (low means high impedance) |
| track | output | 1 | High while the input is being acquired |
| chan_sel | output | 3 | Channel field of the current control word |
| single_ended | output | 1 | Single-ended flag of the last word that reached hold |
| pwr_state | output | 3 | 0 shutdown, 1 full down, 2 fast down, 3 reduced, 4 normal |

## Verification
The serial inputs pass two synchronizer stages and an edge register, so dout, sstrb, track and the drive enables settle on the third system clock after the sclk or cs_n transition that causes them. pwr_state settles one clock after that. The bench holds each sclk half-period for eight system clocks. It reads track and chan_sel at the end of the low half after the relevant falling edge, and sstrb at the end of the high half. The scoreboard monitor compares each expected dout bit at the falling sclk edge that closes that bit's period, so every sample falls several clocks after the value settles and before it can change again.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CTRL_BITS = 8;
  localparam int CH_W      = 3;
  localparam int TRACK_AT  = 5;
  // positions inside the seven bits that follow the start bit
  localparam int F_PD_LSB  = 0;
  localparam int F_SGL     = 2;
  localparam int F_UNI     = 3;
  localparam int F_CH_LSB  = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CTRL, PH_HOLD, PH_STRB, PH_CONV
  } phase_e;

  typedef enum logic [2:0] {
    PW_SHDN = 3'd0, PW_FULL = 3'd1, PW_FAST = 3'd2, PW_REDUCED = 3'd3, PW_ACTIVE = 3'd4
  } pwr_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= RST_VAL;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
  parameter int RES_BITS = 12,
  localparam int IDX_W = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [RES_BITS-1:0] target,
  input  logic                step,
  input  logic [IDX_W-1:0]    idx,
  output logic                dec
);
  logic [RES_BITS-1:0] tgt_q;
  logic [RES_BITS-1:0] acc_q;
  logic [RES_BITS-1:0] trial;

  always_comb begin
    trial = acc_q | ({{(RES_BITS-1){1'b0}}, 1'b1} << idx);
    dec   = (tgt_q >= trial);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      tgt_q <= target;
      acc_q <= '0;
    end else if (step && dec) begin
      acc_q <= trial;
    end
  end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq import sadc_pkg::*; #(
  parameter int RES_BITS = 12,
  localparam int IDX_W = $clog2(RES_BITS),
  localparam int CNT_W = $clog2(CTRL_BITS + 1),
  localparam int SH_W  = CTRL_BITS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             cs_n_s,
  input  logic             din_s,
  input  logic             shdn_n_s,
  input  logic             sar_dec,
  output logic             dout,
  output logic             dout_oe,
  output logic             sstrb,
  output logic             sstrb_oe,
  output logic             track,
  output logic [CH_W-1:0]  chan_sel,
  output logic             single_ended,
  output logic             bipolar,
  output logic [1:0]       pd_bits,
  output logic             hold_pulse,
  output logic             step,
  output logic [IDX_W-1:0] step_idx,
  output logic             busy,
  output logic             done
);
  phase_e           ph;
  logic             sclk_d;
  logic             rise, fall, live;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [IDX_W-1:0] idx;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign live     = ~cs_n_s & shdn_n_s;
  assign step     = live & rise & (ph == PH_CONV);
  assign step_idx = idx;
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; sclk_d <= 1'b0; cnt <= '0; sh <= '0; idx <= '0;
      dout <= 1'b0; sstrb <= 1'b0; track <= 1'b0;
      dout_oe <= 1'b0; sstrb_oe <= 1'b0;
      chan_sel <= '0; single_ended <= 1'b0; bipolar <= 1'b0; pd_bits <= 2'b11;
      hold_pulse <= 1'b0; done <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      hold_pulse <= 1'b0;
      done       <= 1'b0;
      dout_oe    <= ~cs_n_s;
      sstrb_oe   <= ~cs_n_s;
      if (!live) begin
        ph <= PH_IDLE; cnt <= '0;
        track <= 1'b0; sstrb <= 1'b0; dout <= 1'b0;
      end else if (rise) begin
        unique case (ph)
          PH_IDLE: begin
            dout  <= 1'b0;
            sstrb <= 1'b0;
            if (din_s) begin
              sh  <= '0;
              cnt <= CNT_W'(1);
              ph  <= PH_CTRL;
            end
          end
          PH_CTRL: begin
            sh  <= {sh[SH_W-2:0], din_s};
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(CTRL_BITS - 1)) ph <= PH_HOLD;
          end
          PH_HOLD: ;
          PH_STRB: begin
            sstrb <= 1'b1;
            idx   <= IDX_W'(RES_BITS - 1);
            ph    <= PH_CONV;
          end
          PH_CONV: begin
            sstrb <= 1'b0;
            dout  <= sar_dec ^ (bipolar && (idx == IDX_W'(RES_BITS - 1)));
            if (idx == '0) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx - IDX_W'(1);
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end else if (fall) begin
        if (ph == PH_CTRL && cnt == CNT_W'(TRACK_AT)) begin
          track    <= 1'b1;
          chan_sel <= sh[TRACK_AT-2 -: CH_W];
        end
        if (ph == PH_HOLD) begin
          track        <= 1'b0;
          hold_pulse   <= 1'b1;
          single_ended <= sh[F_SGL];
          bipolar      <= ~sh[F_UNI];
          pd_bits      <= sh[F_PD_LSB +: 2];
          ph           <= PH_STRB;
        end
      end
    end
  end

  logic unused_ch;
  assign unused_ch = ^sh[F_CH_LSB +: CH_W];
endmodule

// File: rtl/sadc_pwr.sv
module sadc_pwr import sadc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       shdn_n_s,
  input  logic       busy,
  input  logic       done,
  input  logic [1:0] pd_bits,
  output pwr_e       state
);
  logic [1:0] mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 2'b11;
      state <= PW_ACTIVE;
    end else begin
      if (done) mode <= pd_bits;
      if (!shdn_n_s)  state <= PW_SHDN;
      else if (busy)  state <= PW_ACTIVE;
      else begin
        unique case (mode)
          2'b00:   state <= PW_FULL;
          2'b01:   state <= PW_FAST;
          2'b10:   state <= PW_REDUCED;
          default: state <= PW_ACTIVE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sadc_model.sv
module sadc_model import sadc_pkg::*; #(
  parameter int RES_BITS = 12,
  parameter int SYNC_STAGES = 2,
  localparam int DIFF_W = RES_BITS + 2,
  localparam int EXT_W  = DIFF_W + 1,
  localparam int IDX_W  = $clog2(RES_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              shdn_n,
  input  logic [DIFF_W-1:0] sample_diff,
  output logic              dout,
  output logic              dout_oe,
  output logic              sstrb,
  output logic              sstrb_oe,
  output logic              track,
  output logic [CH_W-1:0]   chan_sel,
  output logic              single_ended,
  output logic [2:0]        pwr_state
);
  localparam int HALF = 2 ** (RES_BITS - 1);

  logic sclk_s, cs_n_s, din_s, shdn_n_s;
  logic sar_dec, hold_pulse, step, busy, done, bipolar;
  logic [IDX_W-1:0] step_idx;
  logic [1:0] pd_bits;
  logic signed [EXT_W-1:0] ext;
  logic [RES_BITS-1:0] target;
  pwr_e pstate;

  sadc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
    .clk(clk), .rst(rst),
    .d({sclk, cs_n, din, shdn_n}),
    .q({sclk_s, cs_n_s, din_s, shdn_n_s})
  );

  sadc_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .din_s(din_s),
    .shdn_n_s(shdn_n_s), .sar_dec(sar_dec), .dout(dout), .dout_oe(dout_oe),
    .sstrb(sstrb), .sstrb_oe(sstrb_oe), .track(track), .chan_sel(chan_sel),
    .single_ended(single_ended), .bipolar(bipolar), .pd_bits(pd_bits),
    .hold_pulse(hold_pulse), .step(step), .step_idx(step_idx), .busy(busy),
    .done(done)
  );

  // offset the difference for bipolar words, then saturate to the code range
  always_comb begin
    ext = {sample_diff[DIFF_W-1], sample_diff} + (bipolar ? EXT_W'(HALF) : EXT_W'(0));
    if (ext[EXT_W-1])                         target = '0;
    else if (ext[EXT_W-2:RES_BITS] != '0)     target = '1;
    else                                      target = ext[RES_BITS-1:0];
  end

  sadc_sar #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst(rst), .load(hold_pulse), .target(target),
    .step(step), .idx(step_idx), .dec(sar_dec)
  );

  sadc_pwr u_pwr (
    .clk(clk), .rst(rst), .shdn_n_s(shdn_n_s), .busy(busy), .done(done),
    .pd_bits(pd_bits), .state(pstate)
  );

  assign pwr_state = pstate;
endmodule

// File: rtl/sadc_model_chk.sv
module sadc_model_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       shdn_n,
  input logic       dout,
  input logic       dout_oe,
  input logic       sstrb,
  input logic       sstrb_oe,
  input logic       track,
  input logic [2:0] pwr_state
);
  logic [2:0] cs_hi_cnt, sd_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi_cnt <= '0;
      sd_lo_cnt <= '0;
    end else begin
      cs_hi_cnt <= !cs_n ? 3'd0 : (cs_hi_cnt == 3'd7 ? cs_hi_cnt : cs_hi_cnt + 3'd1);
      sd_lo_cnt <= shdn_n ? 3'd0 : (sd_lo_cnt == 3'd7 ? sd_lo_cnt : sd_lo_cnt + 3'd1);
    end
  end

  a_r5_released_outputs: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt >= 3'd4) |-> (!dout_oe && !sstrb_oe));

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> (!dout && !sstrb));

  a_r11_shutdown_state: assert property (@(posedge clk) disable iff (rst)
    (sd_lo_cnt >= 3'd4) |-> (pwr_state == 3'd0));

  a_r4_strobe_after_hold: assert property (@(posedge clk) disable iff (rst)
    sstrb |-> (!track && !dout));

  a_r10_awake_while_tracking: assert property (@(posedge clk) disable iff (rst)
    track |-> (pwr_state == 3'd4));
endmodule

bind sadc_model sadc_model_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .shdn_n(shdn_n), .dout(dout),
  .dout_oe(dout_oe), .sstrb(sstrb), .sstrb_oe(sstrb_oe), .track(track),
  .pwr_state(pwr_state)
);

// File: tb/sadc_model_bench.sv
module sadc_model_bench;
  localparam int SH = 8;

  logic clk = 1'b0;
  logic rst, sclk, cs_n, din, shdn_n;
  logic [13:0] sample_diff;
  logic dout, dout_oe, sstrb, sstrb_oe, track, single_ended;
  logic [2:0] chan_sel, pwr_state;

  int checks = 0;
  int fails = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sadc_model u_sadc_model (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .shdn_n(shdn_n),
    .sample_diff(sample_diff), .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb),
    .sstrb_oe(sstrb_oe), .track(track), .chan_sel(chan_sel),
    .single_ended(single_ended), .pwr_state(pwr_state)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] expected(input int diff, input bit uni);
    int v;
    if (uni) v = (diff < 0) ? 0 : ((diff > 4095) ? 4095 : diff);
    else     v = (diff < -2048) ? -2048 : ((diff > 2047) ? 2047 : diff);
    return v[11:0];
  endfunction

  task automatic lo_half(input logic d);
    @(negedge clk);
    sclk = 1'b0;
    din  = d;
    repeat (SH) @(negedge clk);
  endtask

  task automatic hi_half();
    sclk = 1'b1;
    repeat (SH) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    lo_half(d);
    hi_half();
  endtask

  // scoreboard monitor: each expected dout bit is compared when its period ends
  always @(negedge sclk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(dout === e, t, "dout bit", dout, e);
    end
  end

  task automatic convert(input logic [2:0] ch, input bit uni, input bit sgl,
                         input logic [1:0] pd, input int diff, input int lead0,
                         input int pw_before);
    logic [7:0] cb;
    logic [11:0] code;
    cb = {1'b1, ch, uni, sgl, pd};
    code = expected(diff, uni);
    sample_diff = 14'(diff);
    for (int i = 0; i < lead0; i++) pulse(1'b0);
    chk(pwr_state == 3'(pw_before), "R1", "state before start bit", pwr_state, pw_before);
    for (int i = 0; i < 8; i++) begin
      lo_half(cb[7-i]);
      if (i == 4) chk(track == 1'b0, "R2", "track before 5th fall", track, 0);
      if (i == 5) begin
        chk(track == 1'b1, "R2", "track after 5th fall", track, 1);
        chk(chan_sel == ch, "R2", "chan_sel", chan_sel, ch);
      end
      hi_half();
      if (i == 0) chk(pwr_state == 3'd4, "R10", "wake on start bit", pwr_state, 4);
      if (i == 7) chk(sstrb == 1'b0, "R4", "sstrb at 8th bit", sstrb, 0);
    end
    lo_half(1'b0);
    chk(track == 1'b0, "R3", "track after 8th fall", track, 0);
    chk(single_ended == sgl, "R3", "single_ended", single_ended, sgl);
    hi_half();
    chk(sstrb == 1'b1, "R4", "sstrb period 9", sstrb, 1);
    for (int b = 11; b >= 0; b--) begin
      lo_half(1'b0);
      exp_q.push_back(code[b]);
      tag_q.push_back(uni ? "R6 R7" : "R6 R8");
      hi_half();
      if (b == 11) chk(sstrb == 1'b0, "R4", "sstrb period 10", sstrb, 0);
    end
    for (int p = 0; p < 2; p++) begin
      lo_half(1'b0);
      exp_q.push_back(1'b0);
      tag_q.push_back("R6");
      hi_half();
    end
    lo_half(1'b0);
  endtask

  initial begin
    logic [7:0] cb;
    rst = 1'b1; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; shdn_n = 1'b1; sample_diff = '0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0, "R5", "dout_oe after reset", dout_oe, 0);
    chk(sstrb_oe == 1'b0, "R5", "sstrb_oe after reset", sstrb_oe, 0);
    chk(track == 1'b0, "R3", "track after reset", track, 0);
    chk(pwr_state == 3'd4, "R9", "state after reset", pwr_state, 4);

    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b1 && sstrb_oe == 1'b1, "R5", "enables with cs low",
        {dout_oe, sstrb_oe}, 3);

    convert(3'd5, 1'b1, 1'b1, 2'b11, 'hA5C, 3, 4);   // R1 leading zeros, R7
    convert(3'd2, 1'b1, 1'b1, 2'b11, 5000, 0, 4);    // R7 clamp high
    convert(3'd0, 1'b1, 1'b0, 2'b11, -7, 0, 4);      // R7 clamp low
    convert(3'd3, 1'b0, 1'b0, 2'b11, -1, 0, 4);      // R8
    convert(3'd3, 1'b0, 1'b1, 2'b11, -3000, 0, 4);   // R8 clamp
    convert(3'd4, 1'b0, 1'b0, 2'b11, 1234, 0, 4);    // R8
    chk(pwr_state == 3'd4, "R9", "mode 11", pwr_state, 4);

    convert(3'd6, 1'b1, 1'b1, 2'b00, 100, 0, 4);
    chk(pwr_state == 3'd1, "R9", "mode 00", pwr_state, 1);
    convert(3'd7, 1'b1, 1'b1, 2'b01, 4095, 2, 1);    // R10 wake from full down
    chk(pwr_state == 3'd2, "R9", "mode 01", pwr_state, 2);

    // R5: abandon a conversion part way through the result
    cb = 8'b1_100_1_1_11;
    for (int i = 0; i < 8; i++) pulse(cb[7-i]);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    lo_half(1'b0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0 && sstrb_oe == 1'b0, "R5", "enables after abort",
        {dout_oe, sstrb_oe}, 0);
    chk(pwr_state == 3'd2, "R5", "mode kept after abort", pwr_state, 2);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);

    convert(3'd1, 1'b1, 1'b1, 2'b10, 2047, 0, 2);
    chk(pwr_state == 3'd3, "R9", "mode 10", pwr_state, 3);
    convert(3'd4, 1'b1, 1'b0, 2'b00, 1, 1, 3);
    chk(pwr_state == 3'd1, "R9", "mode 00 again", pwr_state, 1);

    // R1: clocks and data with cs high do nothing
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) pulse(1'b1);
    lo_half(1'b0);
    chk(pwr_state == 3'd1, "R1", "no wake with cs high", pwr_state, 1);
    chk(track == 1'b0, "R1", "no track with cs high", track, 0);
    chk(dout_oe == 1'b0, "R5", "dout_oe with cs high", dout_oe, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);

    // R11: hardware shutdown overrides and ignores a full word
    shdn_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(pwr_state == 3'd0, "R11", "shutdown state", pwr_state, 0);
    cb = 8'b1_010_1_1_11;
    for (int i = 0; i < 24; i++) begin
      lo_half(i < 8 ? cb[7-i] : 1'b0);
      if (i == 6) chk(track == 1'b0, "R11", "no track in shutdown", track, 0);
      hi_half();
      if (i == 8) chk(sstrb == 1'b0, "R11", "no strobe in shutdown", sstrb, 0);
      if (i == 12) chk(dout == 1'b0, "R11", "no data in shutdown", dout, 0);
    end
    lo_half(1'b0);
    shdn_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(pwr_state == 3'd1, "R11", "state after release", pwr_state, 1);
    convert(3'd5, 1'b0, 1'b1, 2'b11, -2048, 0, 1);   // R11 recovers, R8 edge
    chk(pwr_state == 3'd4, "R9", "final mode", pwr_state, 4);

    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule